// File: doc/BRIEF.md
# Periodic Interrupt and Alarm Unit

This unit sits beside a time-of-day counter and turns its time-base clock into a programmable periodic tick, a matching square-wave pin and a single active-low interrupt request. One free-running binary divider supplies both the tick and the square wave. A 4-bit rate code picks the divider tap. A 2-bit base select tells the unit which of three time-base frequencies is connected, so a given rate code keeps the same period on any base. The fourth base-select value holds the divider at zero.

The interrupt request has three sources. The alarm source fires when the current time matches a programmed hour, minute and second; any alarm byte can be a wildcard. The periodic source fires on each divider tick. The update source fires when the calendar counter signals that it has finished an update. Each source sets a sticky flag. The flags, with a summary bit, are always visible on an output bus. An enable input per source decides whether its flag drives the request. A one-cycle read strobe clears the flags. A separate clock strobe marks every time-base cycle, or every fourth one.

No data stream crosses this block. Every port is a plain level or a single-cycle strobe, with no valid/ready handshake and no back-pressure.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, `flags` is 0, `irq_n` is 1 and `sqw` is 0.
- R2: For rate codes 3 to 15, the periodic period is 2^(code-1+S) time-base cycles. S is SHIFT_FAST for `base_sel`=0, SHIFT_MID for `base_sel`=1 and 0 for `base_sel`=2.
- R3: Rate codes 1 and 2 give a period of 2^(code+SHIFT_FAST-1) cycles whatever the value of `base_sel`.
- R4: Rate code 0 stops the periodic source: `flags[1]` is never set by it and `sqw` stays 0.
- R5: With `sqw_en`=1 and a nonzero code, `sqw` is a square wave at the periodic rate, high for exactly half of each period. With `sqw_en`=0, `sqw` stays 0.
- R6: The periodic flag `flags[1]` becomes 1 at the same clock edge at which `sqw` falls.
- R7: `base_sel`=3 holds the divider: there are no periodic ticks and `sqw` stays 0.
- R8: A one-cycle `upd_done` sets the update flag `flags[0]` at the next edge.
- R9: On `upd_done`, the alarm flag `flags[2]` is set if every alarm byte either equals the current byte or has bits [7:6]=2'b11, which makes it a wildcard.
- R10: `irq_n` is 0 exactly when some flag in `flags[2:0]` has its enable set. The enables are `en_alarm`, `en_periodic` and `en_update`. `flags[3]` is the inverse of `irq_n`.
- R11: `flag_rd` clears all flags at the next edge. A source event in the same cycle as the read is kept.
- R12: `ck_strobe` is 1 on every cycle when `ck_div4`=0, and on one cycle in every four when `ck_div4`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 2 | Time-base select: 0 fastest, 1 middle, 2 slowest, 3 divider held |
| rate_code | input | 4 | Periodic rate tap select, 0 = off |
| sqw_en | input | 1 | Square-wave output enable |
| ck_div4 | input | 1 | Clock strobe divide-by-4 select |
| now_sec | input | 8 | Current seconds from the calendar |
| now_min | input | 8 | Current minutes from the calendar |
| now_hour | input | 8 | Current hours from the calendar |
| alm_sec | input | 8 | Alarm seconds (wildcard if [7:6]=11) |
| alm_min | input | 8 | Alarm minutes (wildcard if [7:6]=11) |
| alm_hour | input | 8 | Alarm hours (wildcard if [7:6]=11) |
| upd_done | input | 1 | One-cycle pulse at the end of a calendar update |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_update | input | 1 | Update interrupt enable |
| flag_rd | input | 1 | Flag read strobe, clears flags |
| flags | output | 4 | {summary, alarm, periodic, update} |
| irq_n | output | 1 | Active-low interrupt request |
| sqw | output | 1 | Square-wave output |
| ck_strobe | output | 1 | Time-base clock strobe (every cycle or every fourth) |

## Verification
The bench builds the unit with SHIFT_FAST=2 and SHIFT_MID=1. This shrinks the divider to 17 bits, so most rate code and base select pairs can be timed in full. The pairs timed are codes 1 to 12 on the slowest base, codes 1 to 8 on the other two bases, and code 15 on the middle base. The alarm comparison is checked for all 64 combinations of wildcard mask and per-byte mismatch. The interrupt request is checked against all eight enable patterns with every flag set.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int SRC_UPD = 0;
  localparam int SRC_PER = 1;
  localparam int SRC_ALM = 2;
  localparam int NSRC    = 3;

  // Number of low divider bits that form one periodic period (log2 of period).
  function automatic int tap_bits(input logic [3:0] code, input logic [1:0] sel,
                                  input int fast, input int mid);
    int off;
    off = (sel == 2'd0) ? fast : (sel == 2'd1) ? mid : 0;
    if (code == 4'd0) return 1;
    if (code <= 4'd2) return int'(code) + fast - 1;
    return int'(code) - 1 + off;
  endfunction
endpackage

// File: rtl/rate_divider.sv
module rate_divider
  import rtc_irq_pkg::*;
#(
  parameter int SHIFT_FAST = 7,
  parameter int SHIFT_MID  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] base_sel,
  input  logic [3:0] rate_code,
  input  logic       sqw_en,
  input  logic       ck_div4,
  output logic       tick,
  output logic       sqw,
  output logic       ck_strobe
);
  localparam int CNT_W = 15 + SHIFT_FAST;
  localparam int KW    = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] shifted;
  logic [KW-1:0]    k_bits;
  logic [KW-1:0]    k_m1;
  logic             held;
  logic             active;
  logic [1:0]       ck_cnt;

  assign held = (base_sel == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (held) cnt <= '0;
    else           cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    k_bits  = KW'(tap_bits(rate_code, base_sel, SHIFT_FAST, SHIFT_MID));
    k_m1    = k_bits - KW'(1);
    mask    = (CNT_W'(1) << k_bits) - CNT_W'(1);
    shifted = cnt >> k_m1;
    active  = (rate_code != 4'd0) && !held;
    tick    = active && ((cnt & mask) == mask);
    sqw     = sqw_en && active && shifted[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_cnt <= '0;
    else        ck_cnt <= ck_cnt + 2'd1;
  end

  assign ck_strobe = ck_div4 ? (ck_cnt == 2'd3) : 1'b1;
endmodule

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int NBYTES = 3
) (
  input  logic [NBYTES-1:0][7:0] now_t,
  input  logic [NBYTES-1:0][7:0] alm_t,
  output logic                   hit
);
  logic [NBYTES-1:0] byte_ok;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign byte_ok[i] = (alm_t[i][7:6] == 2'b11) || (alm_t[i] == now_t[i]);
  end

  assign hit = &byte_ok;
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import rtc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] en_vec,
  input  logic            rd,
  output logic [NSRC:0]   flags,
  output logic            irq_n
);
  logic [NSRC-1:0] flg;
  logic            any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flg <= '0;
    else if (rd) flg <= set_vec;
    else         flg <= flg | set_vec;
  end

  assign any   = |(flg & en_vec);
  assign flags = {any, flg};
  assign irq_n = !any;
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int SHIFT_FAST = 7,
  parameter int SHIFT_MID  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] base_sel,
  input  logic [3:0] rate_code,
  input  logic       sqw_en,
  input  logic       ck_div4,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic       upd_done,
  input  logic       en_alarm,
  input  logic       en_periodic,
  input  logic       en_update,
  input  logic       flag_rd,
  output logic [3:0] flags,
  output logic       irq_n,
  output logic       sqw,
  output logic       ck_strobe
);
  logic            tick;
  logic            alm_hit;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] en_vec;

  rate_divider #(.SHIFT_FAST(SHIFT_FAST), .SHIFT_MID(SHIFT_MID)) u_div (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .rate_code(rate_code),
    .sqw_en(sqw_en), .ck_div4(ck_div4), .tick(tick), .sqw(sqw),
    .ck_strobe(ck_strobe)
  );

  alarm_match #(.NBYTES(3)) u_alm (
    .now_t({now_hour, now_min, now_sec}),
    .alm_t({alm_hour, alm_min, alm_sec}),
    .hit(alm_hit)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_UPD] = upd_done;
    set_vec[SRC_PER] = tick;
    set_vec[SRC_ALM] = upd_done && alm_hit;
    en_vec           = '0;
    en_vec[SRC_UPD]  = en_update;
    en_vec[SRC_PER]  = en_periodic;
    en_vec[SRC_ALM]  = en_alarm;
  end

  irq_flags u_flg (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .en_vec(en_vec),
    .rd(flag_rd), .flags(flags), .irq_n(irq_n)
  );
endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] base_sel,
  input logic [3:0] rate_code,
  input logic       sqw_en,
  input logic       ck_div4,
  input logic       upd_done,
  input logic       flag_rd,
  input logic [3:0] flags,
  input logic       irq_n,
  input logic       sqw,
  input logic       ck_strobe
);
  // R8
  upd_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> flags[0]);

  // R11
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !upd_done && rate_code == 4'd0) |=> (flags[2:0] == 3'b000));

  // R4
  code0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 4'd0) |=> !$rose(flags[1]));

  // R7
  held_no_sqw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_sel == 2'd3) |-> !sqw);

  // R5
  sqw_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |-> !sqw);

  // R10
  summary_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3] == !irq_n);

  // R12
  strobe_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_div4 |-> ck_strobe);
endmodule

bind rtc_irq_unit rtc_irq_unit_chk u_chk (.*);

// File: tb/rtc_irq_unit_bench.sv
module rtc_irq_unit_bench;
  localparam int SF = 2;
  localparam int SM = 1;

  logic clk = 0, rst_n = 0;
  logic [1:0] base_sel = 2;
  logic [3:0] rate_code = 0;
  logic sqw_en = 1, ck_div4 = 0;
  logic [7:0] now_sec = 8'h56, now_min = 8'h34, now_hour = 8'h12;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hour = 0;
  logic upd_done = 0, en_alarm = 0, en_periodic = 0, en_update = 0, flag_rd = 0;
  logic [3:0] flags;
  logic irq_n, sqw, ck_strobe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_irq_unit #(.SHIFT_FAST(SF), .SHIFT_MID(SM)) u_rtc_irq_unit (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_k(input int code, input int sel);
    int off;
    off = (sel == 0) ? SF : (sel == 1) ? SM : 0;
    return (code <= 2) ? code + SF - 1 : code - 1 + off;
  endfunction

  task automatic clear_flags();
    @(negedge clk); flag_rd = 1;
    @(negedge clk); flag_rd = 0;
  endtask

  task automatic measure(input int code, input int sel);
    int n, g, k;
    k = exp_k(code, sel);
    rate_code = 4'(code); base_sel = 2'(sel);
    @(negedge clk);
    g = 0;
    while (sqw !== 1'b0 && g < 70000) begin @(negedge clk); g++; end
    while (sqw !== 1'b1 && g < 140000) begin @(negedge clk); g++; end
    flag_rd = 1; n = 0;
    do begin @(negedge clk); flag_rd = 0; n++; end while (sqw === 1'b1 && n < 70000);
    // R5 half period high, R6 flag at the falling edge
    check(n == (1 << (k - 1)), "R5", n, 1 << (k - 1));
    check(flags[1] == 1'b1, "R6", flags[1], 1);
    do begin @(negedge clk); n++; end while (sqw === 1'b0 && n < 140000);
    check(n == (1 << k), (code <= 2) ? "R3" : "R2", n, 1 << k);
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_done = 1;
    @(negedge clk); upd_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(flags == 4'd0, "R1", flags, 0);
    check(irq_n == 1'b1, "R1", irq_n, 1);
    check(sqw == 1'b0, "R1", sqw, 0);

    // R2 / R3 / R5 / R6 periods
    for (int c = 1; c <= 12; c++) measure(c, 2);
    for (int c = 1; c <= 8; c++) measure(c, 1);
    for (int c = 1; c <= 8; c++) measure(c, 0);
    measure(15, 1);

    // R4 rate code 0
    rate_code = 0; base_sel = 2; clear_flags();
    begin
      bit bad = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (sqw || flags[1]) bad = 1; end
      check(!bad, "R4", bad, 0);
    end
    // R7 divider held
    rate_code = 3; base_sel = 3; clear_flags();
    begin
      bit bad = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (sqw || flags[1]) bad = 1; end
      check(!bad, "R7", bad, 0);
    end
    // R5 sqw disabled still ticks
    base_sel = 2; sqw_en = 0; clear_flags();
    begin
      bit bad = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (sqw) bad = 1; end
      check(!bad, "R5", bad, 0);
      check(flags[1] == 1'b1, "R5", flags[1], 1);
    end
    sqw_en = 1; rate_code = 0;

    // R9 alarm compare sweep, R8 update flag
    for (int dc = 0; dc < 8; dc++) begin
      for (int mm = 0; mm < 8; mm++) begin
        logic [7:0] a [3];
        logic [7:0] cur [3];
        bit expv;
        cur[0] = now_sec; cur[1] = now_min; cur[2] = now_hour;
        for (int b = 0; b < 3; b++)
          a[b] = dc[b] ? (8'hC0 | 8'(b + mm)) : (mm[b] ? cur[b] + 8'd1 : cur[b]);
        alm_sec = a[0]; alm_min = a[1]; alm_hour = a[2];
        expv = ((dc[0] | ~mm[0]) & (dc[1] | ~mm[1]) & (dc[2] | ~mm[2]));
        clear_flags();
        pulse_upd();
        check(flags[2] == expv, "R9", flags[2], expv);
        check(flags[0] == 1'b1, "R8", flags[0], 1);
      end
    end
    // R9 top bits 10 are not a wildcard
    alm_sec = 8'h80; alm_min = now_min; alm_hour = now_hour;
    clear_flags(); pulse_upd();
    check(flags[2] == 1'b0, "R9", flags[2], 0);

    // R11 read coincident with update event
    alm_sec = now_sec; clear_flags(); pulse_upd();
    alm_sec = now_sec + 8'd1;
    @(negedge clk); flag_rd = 1; upd_done = 1;
    @(negedge clk); flag_rd = 0; upd_done = 0;
    check(flags[2:0] == 3'b001, "R11", flags[2:0], 1);

    // R10 enable sweep with all flags set
    alm_sec = now_sec; rate_code = 1; base_sel = 2;
    repeat (8) @(negedge clk);
    rate_code = 0; pulse_upd();
    check(flags[2:0] == 3'b111, "R10", flags[2:0], 7);
    for (int e = 0; e < 8; e++) begin
      {en_alarm, en_periodic, en_update} = 3'(e);
      @(negedge clk);
      check(irq_n == (e == 0), "R10", irq_n, e == 0);
      check(flags[3] == (e != 0), "R10", flags[3], e != 0);
    end
    // R11 read clears and releases irq
    @(negedge clk); flag_rd = 1;
    @(negedge clk); flag_rd = 0;
    check(flags == 4'd0, "R11", flags, 0);
    check(irq_n == 1'b1, "R11", irq_n, 1);

    // R12 clock strobe
    begin
      int ones = 0, last = -1, gapbad = 0;
      ck_div4 = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); ones += ck_strobe; end
      check(ones == 8, "R12", ones, 8);
      ck_div4 = 1; ones = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (ck_strobe) begin
          if (last >= 0 && i - last != 4) gapbad = 1;
          last = i; ones++;
        end
      end
      check(ones == 4 && !gapbad, "R12", ones, 4);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule